// File: doc/BRIEF.md
# Compressed Page Writeback Placement Controller

This block sits in a memory controller that keeps main memory compressed. A compressed page is built from up to eight 512-byte chunks. Each of its 64 lines is stored at one of four slot sizes, and a per-page metadata entry records that layout. On every last-level-cache writeback the controller receives the page's current metadata entry, the index of the written line and that line's new compressed size code. It decides where the line goes and returns the updated entry.

A line that fits its old slot is rewritten in place. A line that grows is parked uncompressed, at 64 bytes, in an inflation room at the tail of the page. When that room is full the page grows by one chunk, which costs a single line write. Only when neither step is possible does the controller ask for a full page relocation.

The same block also judges, when a metadata entry leaves the metadata cache, whether a repack of the page would give back at least one whole chunk. The compressor, the chunk allocator and the data movement are outside it.

Top module: `cpage_wb_placer`

## Requirements
- R1: While reset is low, `outValid`, `chunkReq`, `relocReq` and `repackReq` are 0.
- R2: The results of a writeback appear one clock after `wbValid` is sampled high. At that point `outValid`=1 and `metaOut` and `placeCode` are valid. The entry is 256 bits, listed here from the most significant bit down:
  - valid[255], zero[254], compressed[253]
  - chunks[252:249]
  - size codes[248:121], with line i at bits 121+2i
  - inflation pointers[120:19], with slot k at bits 19+6k
  - inflated count[18:13]
  - free bytes[12:0]
  
  Size codes map 0/1/2/3 to 0/8/32/64 bytes. `placeCode` is 0 in place, 1 inflation room, 2 room after a new chunk, 3 relocate.
- R3: On a mapped compressed page, a line that is not inflated and whose new size does not exceed its old slot is placed in place (code 0). Its size code is replaced, and free bytes increase by the old size minus the new size.
- R4: A growing line whose page has fewer than 17 inflated lines and at least 64 free bytes goes to the inflation room (code 1). The pointer slot at the old count takes the line index, the count rises by one, free bytes drop by 64, and the line's size code is kept.
- R5: A growing line with fewer than 17 inflated lines, under 64 free bytes and fewer than 8 chunks takes code 2 and pulses `chunkReq`. The chunk count rises by one, the pointer is appended as in R4, and free bytes rise by 448.
- R6: A growing line whose page holds 17 inflated lines, or 8 chunks with under 64 free bytes, takes code 3 and pulses `relocReq`. The entry is returned unchanged.
- R7: A line already listed among the first count inflation pointers stays at its inflation slot (code 1). The entry is returned unchanged.
- R8: On a mapped page whose compressed bit is clear, every writeback is in place (code 0) and the entry is returned unchanged.
- R9: A writeback with a non-zero size code to an unmapped page pulses `chunkReq` and builds a fresh entry:
  - valid=1, zero=0, compressed=1 and one chunk;
  - all size codes zero except the written line's, with no inflated lines;
  - free bytes equal to 512 minus the line size.
- R10: A writeback with size code 0 to an unmapped page leaves the page unallocated: code 0, no `chunkReq`, and the entry returned unchanged.
- R11: One clock after `evictValid` is sampled high, `repackReq` is 1 exactly when the entry is valid and its free bytes are at least 512.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| wbValid | input | 1 | A writeback is presented this cycle |
| wbLine | input | 6 | Index of the written line within the page |
| wbCode | input | 2 | Size code of the newly compressed line |
| evictValid | input | 1 | The entry on `metaIn` is being evicted |
| metaIn | input | 256 | Current metadata entry of the page |
| outValid | output | 1 | `metaOut` and `placeCode` hold a new result |
| metaOut | output | 256 | Updated metadata entry |
| placeCode | output | 2 | Where the line was placed |
| chunkReq | output | 1 | One extra chunk must be allocated |
| relocReq | output | 1 | The whole page must be relocated |
| repackReq | output | 1 | Repacking the evicted page frees a chunk |

## Verification
The table vectors cover five kinds of writeback:
- a shrinking, an equal-sized and a shrink-to-zero rewrite, which check the free-space arithmetic of in-place updates;
- growing lines at exactly 64 free bytes and well above that, which separate the room path from the grow path;
- growth at 7 and at 8 chunks, and at 16 and 17 inflated lines, which pin down each boundary between grow and relocate;
- rewrites of an already inflated line and writes to an uncompressed page, which must leave the entry untouched;
- writes of zero and non-zero lines to unmapped pages, which separate allocation from no-op.

Eviction is tried at 511 and 512 free bytes and on an invalid entry, to place the repack threshold.

// File: rtl/cpage_pkg.sv
package cpage_pkg;
  localparam int LINES       = 64;
  localparam int LINE_W      = $clog2(LINES);
  localparam int CODE_W      = 2;
  localparam int MAX_CHUNKS  = 8;
  localparam int CHUNK_W     = $clog2(MAX_CHUNKS + 1);
  localparam int CHUNK_BYTES = 512;
  localparam int LINE_BYTES  = 64;
  localparam int MAX_INFL    = 17;
  localparam int CNT_W       = 6;
  localparam int FREE_W      = $clog2(MAX_CHUNKS * CHUNK_BYTES + 1);

  typedef struct packed {
    logic                               valid;
    logic                               zero;
    logic                               compressed;
    logic [CHUNK_W-1:0]                 chunks;
    logic [LINES-1:0][CODE_W-1:0]       codes;
    logic [MAX_INFL-1:0][LINE_W-1:0]    ptrs;
    logic [CNT_W-1:0]                   inflCnt;
    logic [FREE_W-1:0]                  freeBytes;
  } meta_t;

  localparam int META_W = $bits(meta_t);

  typedef enum logic [1:0] {
    PL_INPLACE = 2'd0,
    PL_ROOM    = 2'd1,
    PL_GROW    = 2'd2,
    PL_RELOC   = 2'd3
  } place_e;

  typedef struct packed {
    logic   setCode;
    logic   append;
    logic   addChunk;
    logic   allocPage;
    logic   reloc;
    place_e place;
  } strobe_t;

  function automatic logic [FREE_W-1:0] slotBytes(input logic [CODE_W-1:0] code);
    case (code)
      2'd0:    slotBytes = FREE_W'(0);
      2'd1:    slotBytes = FREE_W'(8);
      2'd2:    slotBytes = FREE_W'(32);
      default: slotBytes = FREE_W'(LINE_BYTES);
    endcase
  endfunction
endpackage

// File: rtl/cpage_place_ctrl.sv
module cpage_place_ctrl
  import cpage_pkg::*;
(
  input  logic    clk,
  input  logic    rstN,
  input  logic    wbValid,
  input  logic    mapped,
  input  logic    compressedPg,
  input  logic    zeroLine,
  input  logic    inflHit,
  input  logic    grows,
  input  logic    roomOk,
  input  logic    ptrFull,
  input  logic    chunkFull,
  output strobe_t st
);

  always_comb begin
    st       = '0;
    st.place = PL_INPLACE;
    if (!mapped) begin
      st.allocPage = !zeroLine;
    end else if (!compressedPg) begin
      st.place = PL_INPLACE;
    end else if (inflHit) begin
      st.place = PL_ROOM;
    end else if (!grows) begin
      st.setCode = 1'b1;
    end else if (ptrFull) begin
      st.reloc = 1'b1;
      st.place = PL_RELOC;
    end else if (roomOk) begin
      st.append = 1'b1;
      st.place  = PL_ROOM;
    end else if (!chunkFull) begin
      st.append   = 1'b1;
      st.addChunk = 1'b1;
      st.place    = PL_GROW;
    end else begin
      st.reloc = 1'b1;
      st.place = PL_RELOC;
    end
  end

  // R4 / R5: no pointer is appended to a full pointer list, no chunk added to a full page
  p_append_cap_r4: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && st.append) |-> !ptrFull);
  p_chunk_cap_r5: assert property (@(posedge clk) disable iff (!rstN)
    (wbValid && st.addChunk) |-> (!chunkFull && !roomOk));

endmodule

// File: rtl/cpage_place_dp.sv
module cpage_place_dp
  import cpage_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbValid,
  input  logic              evictValid,
  input  logic [LINE_W-1:0] wbLine,
  input  logic [CODE_W-1:0] wbCode,
  input  meta_t             metaIn,
  input  strobe_t           st,
  output logic              mapped,
  output logic              compressedPg,
  output logic              zeroLine,
  output logic              inflHit,
  output logic              grows,
  output logic              roomOk,
  output logic              ptrFull,
  output logic              chunkFull,
  output logic              outValid,
  output meta_t             metaOut,
  output place_e            placeCode,
  output logic              chunkReq,
  output logic              relocReq,
  output logic              repackReq
);

  logic [FREE_W-1:0]   oldBytes;
  logic [FREE_W-1:0]   newBytes;
  logic [MAX_INFL-1:0] hitVec;
  meta_t               nxt;

  assign oldBytes     = slotBytes(metaIn.codes[wbLine]);
  assign newBytes     = slotBytes(wbCode);
  assign mapped       = metaIn.valid;
  assign compressedPg = metaIn.compressed;
  assign zeroLine     = (wbCode == '0);
  assign grows        = newBytes > oldBytes;
  assign roomOk       = metaIn.freeBytes >= FREE_W'(LINE_BYTES);
  assign ptrFull      = metaIn.inflCnt >= CNT_W'(MAX_INFL);
  assign chunkFull    = metaIn.chunks >= CHUNK_W'(MAX_CHUNKS);

  for (genvar k = 0; k < MAX_INFL; k++) begin : g_match
    assign hitVec[k] = (CNT_W'(k) < metaIn.inflCnt) && (metaIn.ptrs[k] == wbLine);
  end
  assign inflHit = |hitVec;

  always_comb begin
    nxt = metaIn;
    if (st.allocPage) begin
      nxt               = '0;
      nxt.valid         = 1'b1;
      nxt.compressed    = 1'b1;
      nxt.chunks        = CHUNK_W'(1);
      nxt.codes[wbLine] = wbCode;
      nxt.freeBytes     = FREE_W'(CHUNK_BYTES) - newBytes;
    end
    if (st.setCode) begin
      nxt.codes[wbLine] = wbCode;
      nxt.freeBytes     = metaIn.freeBytes + oldBytes - newBytes;
    end
    if (st.append) begin
      for (int k = 0; k < MAX_INFL; k++) begin
        if (CNT_W'(k) == metaIn.inflCnt) nxt.ptrs[k] = wbLine;
      end
      nxt.inflCnt   = metaIn.inflCnt + CNT_W'(1);
      nxt.freeBytes = metaIn.freeBytes - FREE_W'(LINE_BYTES);
    end
    if (st.addChunk) begin
      nxt.chunks    = metaIn.chunks + CHUNK_W'(1);
      nxt.freeBytes = nxt.freeBytes + FREE_W'(CHUNK_BYTES);
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      outValid  <= 1'b0;
      metaOut   <= '0;
      placeCode <= PL_INPLACE;
      chunkReq  <= 1'b0;
      relocReq  <= 1'b0;
      repackReq <= 1'b0;
    end else begin
      outValid  <= wbValid;
      chunkReq  <= wbValid && (st.allocPage || st.addChunk);
      relocReq  <= wbValid && st.reloc;
      repackReq <= evictValid && metaIn.valid &&
                   (metaIn.freeBytes >= FREE_W'(CHUNK_BYTES));
      if (wbValid) begin
        metaOut   <= nxt;
        placeCode <= st.place;
      end
    end
  end

  // R6: a relocation request returns the entry untouched
  p_reloc_keep_r6: assert property (@(posedge clk) disable iff (!rstN)
    relocReq |-> (metaOut == $past(metaIn)));
  // R5: growing adds exactly one chunk and never passes the page limit
  p_grow_one_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && placeCode == PL_GROW) |->
      (metaOut.chunks == $past(metaIn.chunks) + CHUNK_W'(1)));
  p_chunk_limit_r5: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(metaIn.chunks) <= CHUNK_W'(MAX_CHUNKS)) |->
      (metaOut.chunks <= CHUNK_W'(MAX_CHUNKS)));
  // R4: inflated count never exceeds the pointer capacity
  p_infl_limit_r4: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && $past(metaIn.inflCnt) <= CNT_W'(MAX_INFL)) |->
      (metaOut.inflCnt <= CNT_W'(MAX_INFL)));
  // R11: repack only for a valid entry with a whole chunk of slack
  p_repack_gate_r11: assert property (@(posedge clk) disable iff (!rstN)
    repackReq |-> ($past(metaIn.valid) && $past(metaIn.freeBytes) >= FREE_W'(CHUNK_BYTES)));

endmodule

// File: rtl/cpage_wb_placer.sv
module cpage_wb_placer
  import cpage_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              wbValid,
  input  logic [LINE_W-1:0] wbLine,
  input  logic [CODE_W-1:0] wbCode,
  input  logic              evictValid,
  input  logic [META_W-1:0] metaIn,
  output logic              outValid,
  output logic [META_W-1:0] metaOut,
  output logic [1:0]        placeCode,
  output logic              chunkReq,
  output logic              relocReq,
  output logic              repackReq
);

  meta_t   metaInS;
  meta_t   metaOutS;
  place_e  placeS;
  strobe_t st;
  logic    mapped, compressedPg, zeroLine, inflHit, grows, roomOk, ptrFull, chunkFull;

  assign metaInS   = metaIn;
  assign metaOut   = metaOutS;
  assign placeCode = placeS;

  cpage_place_ctrl u_ctrl (
    .clk(clk), .rstN(rstN), .wbValid(wbValid),
    .mapped(mapped), .compressedPg(compressedPg), .zeroLine(zeroLine),
    .inflHit(inflHit), .grows(grows), .roomOk(roomOk),
    .ptrFull(ptrFull), .chunkFull(chunkFull), .st(st)
  );

  cpage_place_dp u_dp (
    .clk(clk), .rstN(rstN), .wbValid(wbValid), .evictValid(evictValid),
    .wbLine(wbLine), .wbCode(wbCode), .metaIn(metaInS), .st(st),
    .mapped(mapped), .compressedPg(compressedPg), .zeroLine(zeroLine),
    .inflHit(inflHit), .grows(grows), .roomOk(roomOk),
    .ptrFull(ptrFull), .chunkFull(chunkFull),
    .outValid(outValid), .metaOut(metaOutS), .placeCode(placeS),
    .chunkReq(chunkReq), .relocReq(relocReq), .repackReq(repackReq)
  );

  // R1: no request is raised without an input in the previous cycle
  p_req_cause_r1: assert property (@(posedge clk) disable iff (!rstN)
    (chunkReq || relocReq) |-> $past(wbValid));

endmodule

// File: tb/sim_cpage_wb_placer.sv
module sim_cpage_wb_placer;
  import cpage_pkg::*;

  logic              clk = 1'b0;
  logic              rstN = 1'b0;
  logic              wbValid = 1'b0;
  logic [LINE_W-1:0] wbLine = '0;
  logic [CODE_W-1:0] wbCode = '0;
  logic              evictValid = 1'b0;
  logic [META_W-1:0] metaIn = '0;
  logic              outValid;
  logic [META_W-1:0] metaOut;
  logic [1:0]        placeCode;
  logic              chunkReq, relocReq, repackReq;

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  cpage_wb_placer u0 (
    .clk(clk), .rstN(rstN), .wbValid(wbValid), .wbLine(wbLine), .wbCode(wbCode),
    .evictValid(evictValid), .metaIn(metaIn), .outValid(outValid), .metaOut(metaOut),
    .placeCode(placeCode), .chunkReq(chunkReq), .relocReq(relocReq), .repackReq(repackReq)
  );

  typedef struct packed {
    int vld; int cmp; int ch; int cnt; int fr; int oldC; int line; int newC; int pre;
    int xPl; int xCh; int xCnt; int xFr; int xCode; int xCr; int xRl; int xVld; int req;
  } vec_t;

  localparam int NV = 13;
  localparam vec_t VECS [NV] = '{
    '{1,1,2, 0,100,3, 5,1,0, 0,2, 0,156,1,0,0,1, 3},  // R3 shrink
    '{1,1,2, 0,100,2, 5,2,0, 0,2, 0,100,2,0,0,1, 3},  // R3 equal size
    '{1,1,5, 0,  7,3, 0,0,0, 0,5, 0, 71,0,0,0,1, 3},  // R3 shrink to zero
    '{1,1,2, 3, 64,1, 5,2,0, 1,2, 4,  0,1,0,0,1, 4},  // R4 exactly 64 free
    '{1,1,2, 0,200,0,63,3,0, 1,2, 1,136,0,0,0,1, 4},  // R4 last line index
    '{1,1,3, 2, 63,1, 5,3,0, 2,4, 3,511,1,1,0,1, 5},  // R5 63 free
    '{1,1,7,16,  0,2, 5,3,0, 2,8,17,448,2,1,0,1, 5},  // R5 boundary 7 chunks / 16 lines
    '{1,1,8, 2, 10,1, 5,2,0, 3,8, 2, 10,1,0,1,1, 6},  // R6 chunks full
    '{1,1,4,17,300,0, 5,1,0, 3,4,17,300,0,0,1,1, 6},  // R6 pointers full
    '{1,1,2, 1, 50,1, 5,3,1, 1,2, 1, 50,1,0,0,1, 7},  // R7 already inflated
    '{1,0,8, 0,  0,3, 5,1,0, 0,8, 0,  0,3,0,0,1, 8},  // R8 uncompressed page
    '{0,0,0, 0,  0,0, 9,2,0, 0,1, 0,480,2,1,0,1, 9},  // R9 allocate
    '{0,0,0, 0,  0,0, 9,0,0, 0,0, 0,  0,0,0,0,0,10}   // R10 zero line stays unmapped
  };

  function automatic meta_t mkMeta(vec_t v);
    meta_t m;
    m = '0;
    m.valid      = v.vld[0];
    m.zero       = !v.vld[0];
    m.compressed = v.cmp[0];
    m.chunks     = CHUNK_W'(v.ch);
    m.inflCnt    = CNT_W'(v.cnt);
    m.freeBytes  = FREE_W'(v.fr);
    m.codes[v.line] = CODE_W'(v.oldC);
    for (int k = 0; k < MAX_INFL; k++) m.ptrs[k] = LINE_W'(v.line + 1);
    if (v.pre != 0) m.ptrs[0] = LINE_W'(v.line);
    return m;
  endfunction

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
    end
  endtask

  task automatic drive(input meta_t m, input int line, input int code,
                       input bit wb, input bit ev);
    @(negedge clk);
    metaIn     = m;
    wbLine     = LINE_W'(line);
    wbCode     = CODE_W'(code);
    wbValid    = wb;
    evictValid = ev;
    @(negedge clk);
    wbValid    = 1'b0;
    evictValid = 1'b0;
  endtask

  initial begin
    meta_t m, o;
    string rq;
    bit same;
    repeat (3) @(negedge clk);
    chk(outValid == 0 && chunkReq == 0 && relocReq == 0 && repackReq == 0, "R1",
        "outputs in reset", {outValid, chunkReq, relocReq, repackReq}, 0);
    rstN = 1'b1;
    @(negedge clk);
    chk(outValid == 0, "R2", "idle outValid", outValid, 0);

    for (int i = 0; i < NV; i++) begin
      vec_t v;
      v  = VECS[i];
      rq = $sformatf("R%0d", v.req);
      m  = mkMeta(v);
      drive(m, v.line, v.newC, 1'b1, 1'b0);
      o = metaOut;
      chk(outValid == 1, "R2", $sformatf("v%0d outValid", i), outValid, 1);
      chk(placeCode == 2'(v.xPl), rq, $sformatf("v%0d placeCode", i), placeCode, v.xPl);
      chk(o.valid == v.xVld[0], rq, $sformatf("v%0d valid", i), o.valid, v.xVld);
      chk(o.chunks == CHUNK_W'(v.xCh), rq, $sformatf("v%0d chunks", i), o.chunks, v.xCh);
      chk(o.inflCnt == CNT_W'(v.xCnt), rq, $sformatf("v%0d inflCnt", i), o.inflCnt, v.xCnt);
      chk(o.freeBytes == FREE_W'(v.xFr), rq, $sformatf("v%0d freeBytes", i), o.freeBytes, v.xFr);
      chk(o.codes[v.line] == CODE_W'(v.xCode), rq, $sformatf("v%0d code", i),
          o.codes[v.line], v.xCode);
      chk(chunkReq == v.xCr[0], rq, $sformatf("v%0d chunkReq", i), chunkReq, v.xCr);
      chk(relocReq == v.xRl[0], rq, $sformatf("v%0d relocReq", i), relocReq, v.xRl);
      if ((v.xPl == 1 || v.xPl == 2) && v.pre == 0)
        chk(o.ptrs[v.cnt] == LINE_W'(v.line), rq, $sformatf("v%0d appended ptr", i),
            o.ptrs[v.cnt], v.line);
      same = (v.xPl == 3) || (v.pre != 0) || (v.vld == 1 && v.cmp == 0) ||
             (v.vld == 0 && v.newC == 0);
      if (same) chk(o == m, rq, $sformatf("v%0d entry unchanged", i), 0, 0);
      if (v.req == 9) begin
        chk(o.zero == 0 && o.compressed == 1, "R9", "alloc flags",
            {o.zero, o.compressed}, 1);
        chk(o.codes[v.line + 1] == 0, "R9", "other code cleared", o.codes[v.line + 1], 0);
      end
    end

    @(negedge clk);
    chk(outValid == 0 && chunkReq == 0, "R2", "no result without writeback",
        {outValid, chunkReq}, 0);

    m = '0; m.valid = 1'b1; m.compressed = 1'b1; m.chunks = CHUNK_W'(3);
    m.freeBytes = FREE_W'(512);
    drive(m, 0, 0, 1'b0, 1'b1);
    chk(repackReq == 1, "R11", "repack at 512 free", repackReq, 1);
    m.freeBytes = FREE_W'(511);
    drive(m, 0, 0, 1'b0, 1'b1);
    chk(repackReq == 0, "R11", "no repack at 511 free", repackReq, 0);
    m.valid = 1'b0; m.freeBytes = FREE_W'(1000);
    drive(m, 0, 0, 1'b0, 1'b1);
    chk(repackReq == 0, "R11", "no repack when invalid", repackReq, 0);
    m.valid = 1'b1;
    drive(m, 0, 0, 1'b0, 1'b0);
    chk(repackReq == 0, "R11", "no repack without eviction", repackReq, 0);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      failures++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

endmodule